// File: doc/BRIEF.md
# Thread-Tagged Operand-Collecting Reservation Queue

This block is a reservation queue that sits in front of a single functional unit and is shared by every hardware thread of a simultaneously multithreaded core. The issue stage writes one renamed instruction per cycle into a free slot. The slot holds the thread number, an instruction identifier, an operation code, a prediction bit, an immediate, the reorder-buffer tag of the destination, and two source operands. Each source operand carries a done flag, the tag of its producer and a 32-bit value.

While an instruction waits in the queue, it watches the result broadcast bus and fills in any outstanding operand whose producer tag matches. Once both operands are present, the instruction may leave for the functional unit. Each cycle the oldest such instruction leaves, through a registered dispatch output. A flush request names one thread and removes all of that thread's work in a single edge. When all slots are taken, the queue raises a stall toward issue. Under the stall contract, issue must withdraw its request, and any write attempted during a stall is discarded.

Top module: `thread_rs_queue`

## Requirements
- R1: After reset, no slot is occupied, `stall` is low and `dispValid` is low.
- R2: The queue holds at most 8 instructions, and `stall` is high exactly when all 8 slots are occupied.
- R3: An issue request presented while `stall` is high is discarded and is never dispatched later.
- R4: An instruction is dispatched only when both of its source operands are done. The dispatched thread, identifier, operation code, prediction bit, immediate and destination tag equal the values written at issue.
- R5: A waiting operand takes `busData` and becomes done at the edge where `busValid` is high and `busTag` equals its producer tag.
- R6: When a broadcast arrives at the same edge as an instruction is written, the incoming instruction captures it for each of its not-done operands whose tag matches.
- R7: At most one instruction is dispatched per cycle, and among the ready instructions the one written earliest goes first.
- R8: At an edge with `flushValid` high, every queued instruction of thread `flushThread` is removed, including while the queue is stalled. An issue request for that thread at the same edge is dropped, and none of these instructions appears on the dispatch output afterwards.
- R9: An instruction written with both operands done appears on the dispatch output after the following edge, provided it is the oldest ready instruction.
- R10: A flush leaves the instructions of all other threads in place, and they still dispatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| issueValid | input | 1 | Issue writes an instruction this cycle |
| issueThread | input | 3 | Thread of the incoming instruction |
| issueIid | input | 8 | Instruction identifier |
| issueOp | input | 6 | Operation / function code |
| issuePred | input | 1 | Prediction bit |
| issueImm | input | 16 | Immediate |
| issueDest | input | 6 | Destination reorder-buffer tag |
| issueSrcADone | input | 1 | First operand already available |
| issueSrcATag | input | 6 | Producer tag of first operand |
| issueSrcAVal | input | 32 | First operand value when done |
| issueSrcBDone | input | 1 | Second operand already available |
| issueSrcBTag | input | 6 | Producer tag of second operand |
| issueSrcBVal | input | 32 | Second operand value when done |
| busValid | input | 1 | Result broadcast present |
| busTag | input | 6 | Reorder-buffer tag of the broadcast result |
| busData | input | 32 | Broadcast result value |
| flushValid | input | 1 | Flush one thread this cycle |
| flushThread | input | 3 | Thread to flush |
| stall | output | 1 | All slots occupied; issue must withdraw |
| dispValid | output | 1 | Dispatch output holds an instruction |
| dispThread | output | 3 | Dispatched thread |
| dispIid | output | 8 | Dispatched identifier |
| dispOp | output | 6 | Dispatched operation code |
| dispPred | output | 1 | Dispatched prediction bit |
| dispImm | output | 16 | Dispatched immediate |
| dispDest | output | 6 | Dispatched destination tag |
| dispSrcA | output | 32 | First operand value |
| dispSrcB | output | 32 | Second operand value |

## Verification
A write, a broadcast capture and a flush each take effect at the edge that samples them. `stall` follows the occupancy left by that edge. Dispatch is registered, so an instruction that is ready after edge k is on the dispatch output after edge k+1. An instruction written already ready therefore shows up two edges after its request was first driven. A waiting instruction shows up one edge after the broadcast that completes it. The bench drives inputs after the falling edge and advances its reference model by exactly one edge for each rising edge. It then compares every output at the following falling edge, so every expected value lines up with the edge count above.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
  localparam int DEPTH  = 8;
  localparam int THR_W  = 3;
  localparam int IID_W  = 8;
  localparam int OP_W   = 6;
  localparam int IMM_W  = 16;
  localparam int TAG_W  = 6;
  localparam int DATA_W = 32;
  localparam int AGE_W  = $clog2(DEPTH);

  // fixed part of an entry, carried unchanged to dispatch
  typedef struct packed {
    logic [THR_W-1:0] thr;
    logic [IID_W-1:0] iid;
    logic [OP_W-1:0]  op;
    logic             pred;
    logic [IMM_W-1:0] imm;
    logic [TAG_W-1:0] dest;
  } rsqPay_t;

  // strobes from control to datapath
  typedef struct packed {
    logic             alloc;
    logic [DEPTH-1:0] allocSel;
    logic             disp;
    logic [DEPTH-1:0] dispSel;
  } rsqCtrl_t;
endpackage

// File: rtl/rsq_ctrl.sv
module rsq_ctrl
  import rsq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             issueValid,
  input  logic [THR_W-1:0] issueThread,
  input  logic             flushValid,
  input  logic [THR_W-1:0] flushThread,
  input  logic [DEPTH-1:0] readyVec,
  input  logic [DEPTH-1:0] threadHit,
  output rsqCtrl_t         ctrl,
  output logic             stall
);
  logic [DEPTH-1:0] validQ;
  logic [AGE_W-1:0] ageQ [DEPTH];
  logic [AGE_W-1:0] ageD [DEPTH];
  logic [DEPTH-1:0] kill, cand, keep, freeSel, pickSel;
  logic [AGE_W-1:0] bestAge, older;
  logic             full, allocOk, found;

  assign full  = &validQ;
  assign stall = full;
  assign kill  = flushValid ? (validQ & threadHit) : '0;
  assign cand  = validQ & readyVec & ~kill;

  // oldest ready entry: smallest rank among candidates
  always_comb begin
    pickSel = '0;
    bestAge = '0;
    found   = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (cand[i] && (!found || ageQ[i] < bestAge)) begin
        pickSel    = '0;
        pickSel[i] = 1'b1;
        bestAge    = ageQ[i];
        found      = 1'b1;
      end
    end
  end

  // lowest free slot
  always_comb begin
    freeSel = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!validQ[i]) begin
        freeSel    = '0;
        freeSel[i] = 1'b1;
      end
    end
  end

  assign allocOk = issueValid && !full && !(flushValid && issueThread == flushThread);
  assign keep    = validQ & ~kill & ~pickSel;

  // rank = number of surviving entries written earlier
  always_comb begin
    older = '0;
    for (int i = 0; i < DEPTH; i++) begin
      older = '0;
      for (int j = 0; j < DEPTH; j++) begin
        if (keep[j] && ageQ[j] < ageQ[i]) older = older + AGE_W'(1);
      end
      if (keep[i])                    ageD[i] = older;
      else if (allocOk && freeSel[i]) ageD[i] = AGE_W'($countones(keep));
      else                            ageD[i] = ageQ[i];
    end
  end

  always_comb begin
    ctrl.alloc    = allocOk;
    ctrl.allocSel = allocOk ? freeSel : '0;
    ctrl.disp     = |pickSel;
    ctrl.dispSel  = pickSel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= '0;
      for (int i = 0; i < DEPTH; i++) ageQ[i] <= '0;
    end else begin
      validQ <= keep | ctrl.allocSel;
      for (int i = 0; i < DEPTH; i++) ageQ[i] <= ageD[i];
    end
  end
endmodule

// File: rtl/rsq_data.sv
module rsq_data
  import rsq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  rsqCtrl_t          ctrl,
  input  rsqPay_t           issuePay,
  input  logic [1:0]        issueDone,
  input  logic [TAG_W-1:0]  issueTag [2],
  input  logic [DATA_W-1:0] issueVal [2],
  input  logic              busValid,
  input  logic [TAG_W-1:0]  busTag,
  input  logic [DATA_W-1:0] busData,
  input  logic [THR_W-1:0]  flushThread,
  output logic [DEPTH-1:0]  readyVec,
  output logic [DEPTH-1:0]  threadHit,
  output logic              dispValid,
  output rsqPay_t           dispPay,
  output logic [DATA_W-1:0] dispSrcA,
  output logic [DATA_W-1:0] dispSrcB
);
  rsqPay_t           payQ   [DEPTH];
  logic [1:0]        doneQ  [DEPTH];
  logic [TAG_W-1:0]  tagQ   [DEPTH][2];
  logic [DATA_W-1:0] valQ   [DEPTH][2];
  rsqPay_t           selPay;
  logic [DATA_W-1:0] selA, selB;
  logic [1:0]        inHit;

  always_comb
    for (int k = 0; k < 2; k++) inHit[k] = busValid && busTag == issueTag[k];

  always_comb
    for (int i = 0; i < DEPTH; i++) begin
      readyVec[i]  = &doneQ[i];
      threadHit[i] = payQ[i].thr == flushThread;
    end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) doneQ[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++)
        for (int k = 0; k < 2; k++) begin
          if (ctrl.allocSel[i])
            doneQ[i][k] <= issueDone[k] | inHit[k];
          else if (busValid && busTag == tagQ[i][k])
            doneQ[i][k] <= 1'b1;
        end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (ctrl.allocSel[i]) payQ[i] <= issuePay;
      for (int k = 0; k < 2; k++) begin
        if (ctrl.allocSel[i]) begin
          tagQ[i][k] <= issueTag[k];
          valQ[i][k] <= issueDone[k] ? issueVal[k] : busData;
        end else if (!doneQ[i][k] && busValid && busTag == tagQ[i][k]) begin
          valQ[i][k] <= busData;
        end
      end
    end
  end

  always_comb begin
    selPay = '0;
    selA   = '0;
    selB   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (ctrl.dispSel[i]) begin
        selPay = rsqPay_t'(selPay | payQ[i]);
        selA   = selA | valQ[i][0];
        selB   = selB | valQ[i][1];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dispValid <= 1'b0;
    else       dispValid <= ctrl.disp;
  end

  always_ff @(posedge clk) begin
    dispPay  <= selPay;
    dispSrcA <= selA;
    dispSrcB <= selB;
  end
endmodule

// File: rtl/thread_rs_queue.sv
module thread_rs_queue
  import rsq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              issueValid,
  input  logic [THR_W-1:0]  issueThread,
  input  logic [IID_W-1:0]  issueIid,
  input  logic [OP_W-1:0]   issueOp,
  input  logic              issuePred,
  input  logic [IMM_W-1:0]  issueImm,
  input  logic [TAG_W-1:0]  issueDest,
  input  logic              issueSrcADone,
  input  logic [TAG_W-1:0]  issueSrcATag,
  input  logic [DATA_W-1:0] issueSrcAVal,
  input  logic              issueSrcBDone,
  input  logic [TAG_W-1:0]  issueSrcBTag,
  input  logic [DATA_W-1:0] issueSrcBVal,
  input  logic              busValid,
  input  logic [TAG_W-1:0]  busTag,
  input  logic [DATA_W-1:0] busData,
  input  logic              flushValid,
  input  logic [THR_W-1:0]  flushThread,
  output logic              stall,
  output logic              dispValid,
  output logic [THR_W-1:0]  dispThread,
  output logic [IID_W-1:0]  dispIid,
  output logic [OP_W-1:0]   dispOp,
  output logic              dispPred,
  output logic [IMM_W-1:0]  dispImm,
  output logic [TAG_W-1:0]  dispDest,
  output logic [DATA_W-1:0] dispSrcA,
  output logic [DATA_W-1:0] dispSrcB
);
  rsqCtrl_t          ctrlS;
  rsqPay_t           issuePay, dispPay;
  logic [DEPTH-1:0]  readyVec, threadHit;
  logic [1:0]        issueDone;
  logic [TAG_W-1:0]  issueTag [2];
  logic [DATA_W-1:0] issueVal [2];

  assign issuePay  = '{thr: issueThread, iid: issueIid, op: issueOp,
                       pred: issuePred, imm: issueImm, dest: issueDest};
  assign issueDone = {issueSrcBDone, issueSrcADone};
  assign issueTag[0] = issueSrcATag;
  assign issueTag[1] = issueSrcBTag;
  assign issueVal[0] = issueSrcAVal;
  assign issueVal[1] = issueSrcBVal;

  rsq_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueThread(issueThread),
    .flushValid(flushValid), .flushThread(flushThread), .readyVec(readyVec),
    .threadHit(threadHit), .ctrl(ctrlS), .stall(stall)
  );

  rsq_data i_data (
    .clk(clk), .rstN(rstN), .ctrl(ctrlS), .issuePay(issuePay), .issueDone(issueDone),
    .issueTag(issueTag), .issueVal(issueVal), .busValid(busValid), .busTag(busTag),
    .busData(busData), .flushThread(flushThread), .readyVec(readyVec),
    .threadHit(threadHit), .dispValid(dispValid), .dispPay(dispPay),
    .dispSrcA(dispSrcA), .dispSrcB(dispSrcB)
  );

  assign dispThread = dispPay.thr;
  assign dispIid    = dispPay.iid;
  assign dispOp     = dispPay.op;
  assign dispPred   = dispPay.pred;
  assign dispImm    = dispPay.imm;
  assign dispDest   = dispPay.dest;
endmodule

// File: rtl/rsq_checker.sv
module rsq_checker
  import rsq_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input rsqCtrl_t         ctrl,
  input logic [DEPTH-1:0] readyVec,
  input logic             stall,
  input logic             flushValid,
  input logic [THR_W-1:0] flushThread,
  input logic             dispValid,
  input logic [THR_W-1:0] dispThread
);
  // R3: nothing is written while the stall is raised
  assert_no_alloc_stalled_R3: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> !ctrl.alloc);

  // R2: a write targets exactly one slot
  assert_alloc_onehot_R2: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.alloc |-> $onehot(ctrl.allocSel));

  // R4: the chosen entry has both operands, as reported by the datapath
  assert_disp_ready_R4: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.disp |-> (ctrl.dispSel & readyVec) != '0);

  // R7: at most one dispatch per cycle
  assert_one_disp_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ctrl.dispSel));

  // R8: the flushed thread never shows on dispatch after the flush edge
  assert_flush_out_R8: assert property (@(posedge clk) disable iff (!rstN)
    flushValid |=> !(dispValid && dispThread == $past(flushThread)));
endmodule

bind thread_rs_queue rsq_checker i_rsqChecker (
  .clk(clk), .rstN(rstN), .ctrl(ctrlS), .readyVec(readyVec), .stall(stall),
  .flushValid(flushValid), .flushThread(flushThread),
  .dispValid(dispValid), .dispThread(dispThread)
);

// File: tb/test_thread_rs_queue.sv
module test_thread_rs_queue;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic iValid = 0, iPred = 0, aDone = 0, bDone = 0, bValid = 0, fValid = 0;
  logic [2:0] iThr = 0, fThr = 0;
  logic [7:0] iIid = 0;
  logic [5:0] iOp = 0, iDest = 0, aTag = 0, bTag = 0, busTag = 0;
  logic [15:0] iImm = 0;
  logic [31:0] aVal = 0, bVal = 0, busData = 0;

  logic stall, dispValid, dispPred;
  logic [2:0] dispThread;
  logic [7:0] dispIid;
  logic [5:0] dispOp, dispDest;
  logic [15:0] dispImm;
  logic [31:0] dispSrcA, dispSrcB;

  thread_rs_queue i_thread_rs_queue (
    .clk(clk), .rstN(rstN), .issueValid(iValid), .issueThread(iThr), .issueIid(iIid),
    .issueOp(iOp), .issuePred(iPred), .issueImm(iImm), .issueDest(iDest),
    .issueSrcADone(aDone), .issueSrcATag(aTag), .issueSrcAVal(aVal),
    .issueSrcBDone(bDone), .issueSrcBTag(bTag), .issueSrcBVal(bVal),
    .busValid(bValid), .busTag(busTag), .busData(busData),
    .flushValid(fValid), .flushThread(fThr), .stall(stall), .dispValid(dispValid),
    .dispThread(dispThread), .dispIid(dispIid), .dispOp(dispOp), .dispPred(dispPred),
    .dispImm(dispImm), .dispDest(dispDest), .dispSrcA(dispSrcA), .dispSrcB(dispSrcB)
  );

  int checks = 0, errors = 0, cycles = 0, iidCnt = 1, lastIid = 0, thr3Seen = 0;
  bit finished = 0;

  // reference model
  bit          mV [8];
  int          mSeq [8];
  logic [2:0]  mThr [8];
  logic [7:0]  mIid [8];
  logic [5:0]  mOp [8], mDest [8];
  logic        mPred [8];
  logic [15:0] mImm [8];
  bit          mD [8][2];
  logic [5:0]  mT [8][2];
  logic [31:0] mVal [8][2];
  int          seqCtr = 0;
  bit eV = 0, eStall = 0;
  logic [2:0] eThr; logic [7:0] eIid; logic [5:0] eOp, eDest; logic ePred;
  logic [15:0] eImm; logic [31:0] eA, eB;
  bit ignored [256];
  bit flushed [256];

  task automatic fail(input string req, input string what, input longint act, input longint exp);
    errors++;
    $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) fail(req, what, act, exp);
  endtask

  task automatic modelStep();
    int p; int slot; bit full;
    logic [5:0] t; bit d;
    full = 1;
    for (int i = 0; i < 8; i++) if (!mV[i]) full = 0;
    p = -1;
    for (int i = 0; i < 8; i++)
      if (mV[i] && mD[i][0] && mD[i][1] && !(fValid && mThr[i] == fThr) &&
          (p < 0 || mSeq[i] < mSeq[p])) p = i;
    eV = (p >= 0);
    if (p >= 0) begin
      eThr = mThr[p]; eIid = mIid[p]; eOp = mOp[p]; ePred = mPred[p];
      eImm = mImm[p]; eDest = mDest[p]; eA = mVal[p][0]; eB = mVal[p][1];
    end
    slot = -1;
    for (int i = 0; i < 8; i++) if (!mV[i] && slot < 0) slot = i;
    for (int i = 0; i < 8; i++) begin
      if (!mV[i]) continue;
      if (fValid && mThr[i] == fThr) begin
        mV[i] = 0; flushed[mIid[i]] = 1;
      end else if (i == p) begin
        mV[i] = 0;
      end else begin
        for (int k = 0; k < 2; k++)
          if (!mD[i][k] && bValid && busTag == mT[i][k]) begin
            mD[i][k] = 1; mVal[i][k] = busData;
          end
      end
    end
    if (iValid) begin
      if (full) ignored[iIid] = 1;
      else if (fValid && iThr == fThr) flushed[iIid] = 1;
      else begin
        mV[slot] = 1; mSeq[slot] = seqCtr; seqCtr++;
        mThr[slot] = iThr; mIid[slot] = iIid; mOp[slot] = iOp; mPred[slot] = iPred;
        mImm[slot] = iImm; mDest[slot] = iDest;
        for (int k = 0; k < 2; k++) begin
          t = (k == 0) ? aTag : bTag;
          d = (k == 0) ? aDone : bDone;
          mT[slot][k] = t;
          if (d) begin
            mD[slot][k] = 1; mVal[slot][k] = (k == 0) ? aVal : bVal;
          end else if (bValid && busTag == t) begin
            mD[slot][k] = 1; mVal[slot][k] = busData;   // R6 same-edge capture
          end else begin
            mD[slot][k] = 0; mVal[slot][k] = 0;
          end
        end
      end
    end
    eStall = 1;
    for (int i = 0; i < 8; i++) if (!mV[i]) eStall = 0;
  endtask

  task automatic compare();
    check(stall === eStall, "R2", "stall", stall, eStall);
    check(dispValid === eV, "R7", "dispValid", dispValid, eV);
    if (eV && dispValid) begin
      check({dispThread, dispIid, dispOp, dispPred, dispImm, dispDest} ===
            {eThr, eIid, eOp, ePred, eImm, eDest}, "R4", "dispatch fields",
            {dispThread, dispIid, dispOp, dispPred, dispImm, dispDest},
            {eThr, eIid, eOp, ePred, eImm, eDest});
      check(dispSrcA === eA, "R5", "operand A", dispSrcA, eA);
      check(dispSrcB === eB, "R5", "operand B", dispSrcB, eB);
    end
    if (dispValid) begin
      check(!flushed[dispIid], "R8", "flushed iid dispatched", dispIid, 0);
      check(!ignored[dispIid], "R3", "stalled issue dispatched", dispIid, 0);
      if (dispThread == 3'd3) thr3Seen++;
    end
  endtask

  task automatic cyc();
    modelStep();
    @(posedge clk);
    @(negedge clk);
    compare();
    iValid = 0; bValid = 0; fValid = 0;
  endtask

  task automatic putIssue(input int thr, input bit dA, input int tA, input int vA,
                          input bit dB, input int tB, input int vB);
    iValid = 1; iThr = thr[2:0]; iIid = iidCnt[7:0]; lastIid = iidCnt;
    ignored[iidCnt[7:0]] = 0; flushed[iidCnt[7:0]] = 0;
    iOp = 6'(iidCnt * 5); iPred = iidCnt[0]; iImm = 16'(iidCnt * 37); iDest = 6'(iidCnt + 3);
    aDone = dA; aTag = 6'(tA); aVal = 32'(vA);
    bDone = dB; bTag = 6'(tB); bVal = 32'(vB);
    iidCnt++;
  endtask

  task automatic putBus(input int tag, input int data);
    bValid = 1; busTag = 6'(tag); busData = 32'(data);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !finished) begin
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 100000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int a, b, c;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    // R1 reset state
    check(stall === 1'b0, "R1", "stall after reset", stall, 0);
    check(dispValid === 1'b0, "R1", "dispValid after reset", dispValid, 0);

    // R9 latency of a ready instruction
    putIssue(0, 1, 1, 32'h11, 1, 2, 32'h22); a = lastIid;
    cyc();
    check(dispValid === 1'b0, "R9", "not yet dispatched", dispValid, 0);
    cyc();
    check(dispValid === 1'b1 && dispIid == 8'(a), "R9", "dispatched iid", dispIid, a);
    repeat (2) cyc();

    // R5/R7 waiting entries completed by one broadcast, oldest first
    putIssue(1, 0, 5, 0, 1, 7, 32'hA1); a = lastIid; cyc();
    putIssue(2, 0, 5, 0, 1, 7, 32'hA2); b = lastIid; cyc();
    putIssue(3, 1, 6, 32'hB3, 0, 5, 0); c = lastIid; cyc();
    check(dispValid === 1'b0, "R4", "waiting entries held", dispValid, 0);
    putBus(5, 32'hCAFE); cyc();
    cyc();
    check(dispValid === 1'b1 && dispIid == 8'(a), "R7", "oldest first", dispIid, a);
    check(dispSrcA === 32'hCAFE, "R5", "captured value", dispSrcA, 32'hCAFE);
    cyc();
    check(dispIid == 8'(b), "R7", "second", dispIid, b);
    cyc();
    check(dispIid == 8'(c) && dispSrcB === 32'hCAFE, "R5", "third", dispIid, c);
    repeat (2) cyc();

    // R6 broadcast at the write edge
    putIssue(1, 0, 9, 0, 1, 3, 32'h33); putBus(9, 32'hBEEF); a = lastIid;
    cyc(); cyc();
    check(dispValid === 1'b1 && dispIid == 8'(a) && dispSrcA === 32'hBEEF, "R6",
          "same-edge capture", dispSrcA, 32'hBEEF);
    repeat (3) cyc();

    // R2/R3/R8/R10 fill, stall, flush while stalled
    for (int i = 0; i < 8; i++) begin
      putIssue((i % 2 == 0) ? 2 : 3, 0, 20, 0, 1, 4, 100 + i);
      cyc();
    end
    check(stall === 1'b1, "R2", "stall when 8 held", stall, 1);
    putIssue(1, 1, 1, 1, 1, 1, 1); a = lastIid;
    cyc();
    check(stall === 1'b1 && ignored[a[7:0]], "R3", "issue under stall dropped", stall, 1);
    thr3Seen = 0;
    fValid = 1; fThr = 3'd2;
    cyc();
    check(stall === 1'b0, "R8", "flush while stalled frees slots", stall, 0);
    putBus(20, 32'h5150); cyc();
    repeat (8) cyc();
    check(thr3Seen == 4, "R10", "other thread survives flush", thr3Seen, 4);

    // mixed traffic
    for (int n = 0; n < 400; n++) begin
      if (($urandom % 10) < 6 && iidCnt < 250)
        putIssue($urandom % 4, 1'($urandom % 2), $urandom % 8, $urandom,
                 1'($urandom % 2), $urandom % 8, $urandom);
      if (($urandom % 10) < 4) putBus($urandom % 8, $urandom);
      if (($urandom % 20) == 0) begin fValid = 1; fThr = 3'($urandom % 4); end
      cyc();
    end
    for (int t = 0; t < 4; t++) begin fValid = 1; fThr = 3'(t); cyc(); end
    repeat (4) cyc();
    check(stall === 1'b0 && dispValid === 1'b0, "R8", "drained after flushes", dispValid, 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule